// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block holds a bank of independent 32-bit down-counters behind a single master enable. Each is reached through a simple single-cycle register bus with address, write data, write strobe, read strobe and combinational read data. Each channel counts down from a programmable start value. When it passes zero it restarts from that value, adds one to a saturating wrap count and raises a sticky event flag. Software can treat the inverted count as a free-running up-counter.

The count is read in two steps. Reading a channel's wrap-count register returns the number of wraps, and in the same cycle it copies the live counter into a separate captured-count register. A later read of that register returns a value consistent with the wrap count. Event flags are cleared by writing ones. Each flag has an enable bit, and all enabled flags are ORed onto a single interrupt line. A tick-enable input stands in for the counting clock.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads 0, except each channel's start-value register, which reads 0xFFFFFFFF. The interrupt output is 0.
- R2: A channel's counter changes only when the tick input is high, master enable (bit 0 at byte address 0x00) is 1 and the channel's run bit (bit 0 at channel offset 0x00) is 1. The one exception is the load of R3.
- R3: Writing the run bit from 0 to 1 loads the counter from the start-value register (channel offset 0x04).
- R4: On each qualifying tick the counter decreases by exactly one while it is above zero.
- R5: On a qualifying tick with the counter at zero, the counter reloads from the start value, the wrap count (offset 0x0C) increments and saturates at all ones, and event bit 0 (offset 0x10) is set.
- R6: A read at offset 0x0C returns the wrap count and copies the live counter into the captured-count register (offset 0x08). That register does not change at any other time.
- R7: Writing 1 to bit 0 at offset 0x14 clears the event bit. Writing 0 there leaves it unchanged.
- R8: The interrupt output is the OR over channels of event bit AND event-enable bit (bit 0 at offset 0x18). A 0 enable bit suppresses that channel.
- R9: Byte address 0x10 returns a fixed revision constant. Writes to it, to the captured-count register and to the wrap-count register have no effect.
- R10: Channel n occupies bytes 0x20+0x20*n to 0x3F+0x20*n. Accesses to one channel do not alter another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counting-clock enable |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Combined interrupt |

## Verification
The counter is tried with tick pulses while the master enable is off, while the run bit is off, and while both are on. This separates the two gating terms from the tick input itself. Short start values (5 and 2) drive channels across zero, so a reload is distinguished from a plain decrement and from the wrap-count increment. Reads of the captured-count register with and without a preceding wrap-count read show whether it is refreshed only by the capture. Mask and clear patterns on two channels show that enabled and suppressed flags are combined correctly.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // window layout: upper address bits select the window, low five bits the register
  localparam int WIN_SHIFT = 5;

  // top window offsets
  localparam logic [4:0] TOP_CTRL = 5'h00;
  localparam logic [4:0] TOP_REV  = 5'h10;

  // channel window offsets
  localparam logic [4:0] CH_CFG  = 5'h00;
  localparam logic [4:0] CH_RLD  = 5'h04;
  localparam logic [4:0] CH_CUR  = 5'h08;
  localparam logic [4:0] CH_OVF  = 5'h0C;
  localparam logic [4:0] CH_STS  = 5'h10;
  localparam logic [4:0] CH_CLR  = 5'h14;
  localparam logic [4:0] CH_MSK  = 5'h18;
endpackage

// File: rtl/gpt_addr_dec.sv
module gpt_addr_dec #(
  parameter int AW     = 8,
  parameter int NUM_CH = 4
) (
  input  logic [AW-1:0]     addr,
  output logic              top_hit,
  output logic [NUM_CH-1:0] ch_hit,
  output logic [4:0]        offset
);
  import gpt_pkg::*;
  localparam int WIN_W = AW - WIN_SHIFT;

  logic [WIN_W-1:0] win;

  assign win     = addr[AW-1:WIN_SHIFT];
  assign offset  = addr[WIN_SHIFT-1:0];
  assign top_hit = (win == '0);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_hit
      assign ch_hit[g] = (win == WIN_W'(g + 1));
    end
  endgenerate

  always_comb begin
    assert ($countones({top_hit, ch_hit}) <= 1); // R10 windows never overlap
  end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic          sel_rd,
  input  logic [4:0]    offset,
  input  logic [DW-1:0] wdata,
  input  logic          tick_ok,
  output logic [DW-1:0] rdata,
  output logic          irq_o,
  output logic          sts_o,
  output logic [DW-1:0] cnt_o,
  output logic          load_o
);
  import gpt_pkg::*;

  // arithmetic kept in functions so the bench can restate it independently
  function automatic logic [DW-1:0] f_step(input logic [DW-1:0] c, input logic [DW-1:0] rl);
    return (c == '0) ? rl : c - DW'(1);
  endfunction

  function automatic logic [DW-1:0] f_sat_inc(input logic [DW-1:0] v);
    return (v == '1) ? v : v + DW'(1);
  endfunction

  function automatic logic [DW-1:0] f_bit(input logic b);
    return {{(DW-1){1'b0}}, b};
  endfunction

  logic          run_q, msk_q, sts_q;
  logic [DW-1:0] rld_q, cnt_q, cur_q, ovf_q;

  // named internal events
  logic wr_cfg, wr_rld, wr_clr, wr_msk;
  logic load_evt, tick_evt, wrap_evt, snap_evt;

  assign wr_cfg   = sel_wr && (offset == CH_CFG);
  assign wr_rld   = sel_wr && (offset == CH_RLD);
  assign wr_clr   = sel_wr && (offset == CH_CLR) && wdata[0];
  assign wr_msk   = sel_wr && (offset == CH_MSK);
  assign load_evt = wr_cfg && wdata[0] && !run_q;
  assign tick_evt = tick_ok && run_q && !load_evt;
  assign wrap_evt = tick_evt && (cnt_q == '0);
  assign snap_evt = sel_rd && (offset == CH_OVF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      msk_q <= 1'b0;
      rld_q <= '1;
    end else begin
      if (wr_cfg) run_q <= wdata[0];
      if (wr_msk) msk_q <= wdata[0];
      if (wr_rld) rld_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_evt) begin
      cnt_q <= rld_q;
    end else if (tick_evt) begin
      cnt_q <= f_step(cnt_q, rld_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      sts_q <= 1'b0;
    end else begin
      if (wrap_evt) ovf_q <= f_sat_inc(ovf_q);
      if (wrap_evt)    sts_q <= 1'b1;
      else if (wr_clr) sts_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_q <= '0;
    else if (snap_evt) cur_q <= cnt_q;
  end

  always_comb begin
    rdata = '0;
    if (sel_rd) begin
      case (offset)
        CH_CFG:  rdata = f_bit(run_q);
        CH_RLD:  rdata = rld_q;
        CH_CUR:  rdata = cur_q;
        CH_OVF:  rdata = ovf_q;
        CH_STS:  rdata = f_bit(sts_q);
        CH_MSK:  rdata = f_bit(msk_q);
        default: rdata = '0;
      endcase
    end
  end

  assign irq_o  = sts_q && msk_q;
  assign sts_o  = sts_q;
  assign cnt_o  = cnt_q;
  assign load_o = load_evt;

  AST_LOAD_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt_q == $past(rld_q)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_evt && !load_evt) |=> $stable(cnt_q)); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DW'(1)); // R4
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (sts_q && cnt_q == $past(rld_q))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q == '1) |=> (ovf_q == '1)); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_evt |=> $stable(cur_q)); // R6
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wrap_evt) |=> !sts_q); // R7
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank #(
  parameter int          AW     = 8,
  parameter int          DW     = 32,
  parameter int          NUM_CH = 4,
  parameter logic [31:0] REV_ID = 32'h0001_0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  import gpt_pkg::*;

  logic              top_hit;
  logic [NUM_CH-1:0] ch_hit;
  logic [4:0]        offset;
  logic              glb_q;
  logic              tick_ok;

  logic [NUM_CH-1:0]         irq_vec, sts_vec, load_vec;
  logic [NUM_CH-1:0][DW-1:0] rd_vec, cnt_vec;
  logic [DW-1:0]             top_rdata, ch_rdata;

  gpt_addr_dec #(.AW(AW), .NUM_CH(NUM_CH)) u_dec (
    .addr    (bus_addr),
    .top_hit (top_hit),
    .ch_hit  (ch_hit),
    .offset  (offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glb_q <= 1'b0;
    else if (bus_wr && top_hit && offset == TOP_CTRL) glb_q <= bus_wdata[0];
  end

  assign tick_ok = tick_en && glb_q;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      gpt_channel #(.DW(DW)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_wr  (bus_wr && ch_hit[g]),
        .sel_rd  (bus_rd && ch_hit[g]),
        .offset  (offset),
        .wdata   (bus_wdata),
        .tick_ok (tick_ok),
        .rdata   (rd_vec[g]),
        .irq_o   (irq_vec[g]),
        .sts_o   (sts_vec[g]),
        .cnt_o   (cnt_vec[g]),
        .load_o  (load_vec[g])
      );
    end
  endgenerate

  always_comb begin
    top_rdata = '0;
    if (bus_rd && top_hit) begin
      if (offset == TOP_CTRL)     top_rdata = {{(DW-1){1'b0}}, glb_q};
      else if (offset == TOP_REV) top_rdata = DW'(REV_ID);
    end
  end

  always_comb begin
    ch_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) ch_rdata = ch_rdata | rd_vec[i];
  end

  assign bus_rdata = top_rdata | ch_rdata;
  assign irq       = |irq_vec;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_q && load_vec == '0) |=> $stable(cnt_vec)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_vec != '0)); // R8
  AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && top_hit) |-> ch_rdata == '0); // R10
endmodule

// File: tb/sim_gp_timer_bank.sv
module sim_gp_timer_bank;
  localparam logic [31:0] REV = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  gp_timer_bank #(.REV_ID(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] ch_base(input int n);
    return 8'(8'h20 + 8'h20 * n);
  endfunction

  // monitor: compares read data against the scoreboard in the strobe cycle
  always @(negedge clk) begin
    if (bus_rd) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(ch_base(0) + 8'h00, 32'h0, "R1 cfg");
    rd(ch_base(0) + 8'h04, 32'hFFFF_FFFF, "R1 reload");
    rd(ch_base(0) + 8'h08, 32'h0, "R1 cur");
    rd(ch_base(0) + 8'h0C, 32'h0, "R1 ovf");
    rd(ch_base(0) + 8'h10, 32'h0, "R1 status");
    rd(ch_base(0) + 8'h18, 32'h0, "R1 mask");
    chk_irq(1'b0, "R1 irq");
    rd(8'h10, REV, "R9 revision");

    // R3 load on run, R2 gated by master enable
    wr(ch_base(0) + 8'h04, 32'd5);
    wr(ch_base(0) + 8'h00, 32'd1);
    ticks(3);
    rd(ch_base(0) + 8'h0C, 32'd0, "R2 ovf");
    rd(ch_base(0) + 8'h08, 32'd5, "R3 R2 loaded and held");

    // R4 down count
    wr(8'h00, 32'd1);
    ticks(3);
    rd(ch_base(0) + 8'h0C, 32'd0, "R4 ovf");
    rd(ch_base(0) + 8'h08, 32'd2, "R4 count after 3");
    ticks(1);
    rd(ch_base(0) + 8'h08, 32'd2, "R6 no refresh without capture");

    // R5 wrap, R8 mask, R7 clear
    ticks(2);
    rd(ch_base(0) + 8'h0C, 32'd1, "R5 wrap count");
    rd(ch_base(0) + 8'h08, 32'd5, "R5 reloaded");
    rd(ch_base(0) + 8'h10, 32'd1, "R5 status set");
    chk_irq(1'b0, "R8 masked");
    wr(ch_base(0) + 8'h18, 32'd1);
    chk_irq(1'b1, "R8 unmasked");
    wr(ch_base(0) + 8'h14, 32'd0);
    rd(ch_base(0) + 8'h10, 32'd1, "R7 write 0 no effect");
    wr(ch_base(0) + 8'h14, 32'd1);
    rd(ch_base(0) + 8'h10, 32'd0, "R7 cleared");
    chk_irq(1'b0, "R8 after clear");

    // R10 second channel, R2 run bit gate
    wr(ch_base(1) + 8'h04, 32'd2);
    rd(ch_base(1) + 8'h0C, 32'd0, "R2 idle channel ovf");
    rd(ch_base(1) + 8'h08, 32'd0, "R2 idle channel did not count");
    wr(ch_base(1) + 8'h00, 32'd1);
    ticks(3);
    rd(ch_base(1) + 8'h0C, 32'd1, "R10 ch1 wrap");
    rd(ch_base(1) + 8'h08, 32'd2, "R10 ch1 reloaded");
    rd(ch_base(1) + 8'h10, 32'd1, "R10 ch1 status");
    chk_irq(1'b0, "R8 ch1 suppressed");
    rd(ch_base(0) + 8'h0C, 32'd1, "R10 ch0 ovf unchanged");
    rd(ch_base(0) + 8'h08, 32'd2, "R10 ch0 count");
    wr(ch_base(1) + 8'h18, 32'd1);
    chk_irq(1'b1, "R8 ch1 enabled");

    // R9 read-only registers
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, REV, "R9 revision after write");
    wr(ch_base(0) + 8'h08, 32'h1234);
    rd(ch_base(0) + 8'h08, 32'd2, "R9 captured count after write");
    wr(ch_base(0) + 8'h0C, 32'h55);
    rd(ch_base(0) + 8'h0C, 32'd1, "R9 wrap count after write");

    // R2 master enable off stops counting
    wr(8'h00, 32'd0);
    rd(8'h00, 32'd0, "R2 ctrl readback");
    ticks(4);
    rd(ch_base(0) + 8'h0C, 32'd1, "R2 ovf frozen");
    rd(ch_base(0) + 8'h08, 32'd2, "R2 count frozen");

    // R3 reprogram sequence
    wr(ch_base(0) + 8'h00, 32'd0);
    wr(ch_base(0) + 8'h04, 32'd7);
    wr(ch_base(0) + 8'h00, 32'd1);
    rd(ch_base(0) + 8'h00, 32'd1, "R3 run bit");
    rd(ch_base(0) + 8'h0C, 32'd1, "R3 ovf");
    rd(ch_base(0) + 8'h08, 32'd7, "R3 reload applied");

    // R10 last channel window
    wr(ch_base(3) + 8'h04, 32'hA);
    rd(ch_base(3) + 8'h04, 32'hA, "R10 ch3 reload");
    rd(ch_base(2) + 8'h04, 32'hFFFF_FFFF, "R10 ch2 untouched");

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule